// File: doc/BRIEF.md
# Byte-Lane 64-bit Register File Interface

This block is a memory-mapped slave that lets a host read and write the control state of an interrupt dispatch engine. Accesses can be 1, 2, 4 or 8 bytes wide. The storage is a bank of 64-bit control words plus two packed byte tables: a per-source vector table and a per-source route table. Each request address is split into an aligned 64-bit word address and a byte offset within that word. Writes are merged into the selected word under a lane mask that is shifted to the offset. Reads return the selected word shifted down to the offset and trimmed to the access width. All data is little-endian: byte k of a word sits in bits [8k+7:8k].

Some locations carry side effects instead of plain storage:
- A status word reads as the in-service vector with the masked sources removed.
- A clear word stores nothing. A write to it sends a one-cycle clear strobe to the dispatch logic.
- Two automatic-control words absorb writes and read as zero.
- Every write to the mask word presents the previous and the merged mask to the dispatch logic for one cycle, so that logic can work out which sources were newly unmasked or newly masked.

A lookup port gives the dispatch logic registered access to one byte of each table, chosen by source number.

Top module: `bytelane_regfile`

## Requirements
- R1: The byte offset is `req_addr[2:0]` and the word is chosen by `req_addr` with those bits forced to zero. Read data equals the selected word shifted right by 8×offset, ANDed with the size mask. The size mask is 0xFF, 0xFFFF, 0xFFFFFFFF or all ones for `req_bytes` of 1, 2, 4 or 8.
- R2: A write replaces only the bits under the size mask shifted left by 8×offset, taking them from `req_wdata` ANDed with the size mask and shifted by the same amount. All other bits of the word keep their value. This holds for the mask (0x008), edge (0x010), message-enable (0x018) and polarity (0x040) words.
- R3: The request gets an error response, read data zero, and no state change in these cases:
  - `req_bytes` is not 1, 2, 4 or 8.
  - The offset is not a multiple of the size, which covers unaligned and word-crossing accesses.
- R4: A request to an address that maps to no word gets an error response, read data zero, and no state change.
- R5: Each request accepted at a clock edge produces `rsp_valid` for exactly the following cycle, together with `rsp_rdata` and `rsp_err`. A write returns read data zero.
- R6: A read of the status word (0x038) returns `insvc & ~irq_mask`. A write to it changes nothing and is not an error.
- R7: A write to the clear word (0x030) stores nothing. In the next cycle it pulses `clr_valid` for one cycle, with `clr_bits` holding the shifted, masked write data. A read of the clear word returns zero.
- R8: The two automatic-control words (0x020 and 0x028) accept writes without effect and read back as zero, with no error.
- R9: The identity word (0x000) reads the `ID_VALUE` parameter. Writes to it are ignored and are not an error.
- R10: Each table holds NUM_SRC bytes starting at its base: vector table at 0x100, route table at 0x200. Source k sits at base+k, and accesses index the table by address minus base. Addresses at or beyond base+NUM_SRC are unmapped.
- R11: Every accepted write to the mask word pulses `mask_chg_valid` for one cycle in the next cycle. `mask_chg_old` holds the previous mask and `mask_chg_new` holds the merged mask. `irq_mask` changes only in such a cycle.
- R12: One cycle after `lk_idx` is presented, `lk_vec` and `lk_route` hold the vector-table and route-table bytes of that source.
- R13: A synchronous reset clears all control words, `rsp_valid`, `rsp_err` and both strobes. Table contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_bytes | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data, right-aligned |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Read data, right-aligned |
| rsp_err | output | 1 | Illegal size, misalignment or unmapped address |
| insvc | input | 64 | In-service vector from the dispatch logic |
| lk_idx | input | $clog2(NUM_SRC) | Source number for table lookup |
| lk_vec | output | 8 | Vector-table byte of lk_idx, registered |
| lk_route | output | 8 | Route-table byte of lk_idx, registered |
| irq_mask | output | 64 | Mask word |
| irq_edge | output | 64 | Edge-select word |
| irq_pol | output | 64 | Polarity word |
| irq_msi_en | output | 64 | Message-enable word |
| mask_chg_valid | output | 1 | Mask write notification |
| mask_chg_old | output | 64 | Mask before the write |
| mask_chg_new | output | 64 | Mask after the write |
| clr_valid | output | 1 | Clear strobe |
| clr_bits | output | 64 | Bits to clear |

## Verification
The assertions check every cycle that:
- each request is answered exactly one cycle later;
- an error response or a write response carries zero data;
- a one-byte read never sets bits above the low byte;
- the mask output moves only in a notification cycle, and the notified new value is the value that takes effect;
- clear and mask strobes appear only after a write.

Only the bench scenarios can show the byte-lane arithmetic itself. That covers merges at each offset, sub-word reads of the tables, the status formula against a driven in-service vector, and the clear-strobe bit positions. It also covers the discard rules for identity, automatic-control and status writes, which are confirmed by reading the words back.

// File: rtl/brf_pkg.sv
`timescale 1ns/1ps
package brf_pkg;
  localparam int REG_W = 64;
  localparam int LANES = REG_W / 8;

  // word offsets of the control bank (byte addresses, 8-aligned)
  localparam int OFS_ID     = 'h000;
  localparam int OFS_MASK   = 'h008;
  localparam int OFS_EDGE   = 'h010;
  localparam int OFS_MSIEN  = 'h018;
  localparam int OFS_AUTO0  = 'h020;
  localparam int OFS_AUTO1  = 'h028;
  localparam int OFS_CLEAR  = 'h030;
  localparam int OFS_STATUS = 'h038;
  localparam int OFS_POL    = 'h040;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ID, SEL_MASK, SEL_EDGE, SEL_MSIEN, SEL_AUTO,
    SEL_CLEAR, SEL_STATUS, SEL_POL, SEL_VEC, SEL_RTE
  } sel_e;

  function automatic logic [REG_W-1:0] size_mask(input logic [3:0] nbytes);
    case (nbytes)
      4'd1:    size_mask = 64'h0000_0000_0000_00FF;
      4'd2:    size_mask = 64'h0000_0000_0000_FFFF;
      4'd4:    size_mask = 64'h0000_0000_FFFF_FFFF;
      4'd8:    size_mask = '1;
      default: size_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/brf_lane.sv
`timescale 1ns/1ps
module brf_lane
  import brf_pkg::*;
(
  input  logic [2:0]       off,
  input  logic [3:0]       nbytes,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] rword,
  output logic             size_ok,
  output logic [REG_W-1:0] lane_mask,
  output logic [REG_W-1:0] wdata_sh,
  output logic [REG_W-1:0] rdata_sh
);
  logic [REG_W-1:0] smask;
  logic [5:0]       sh;

  assign smask = size_mask(nbytes);
  assign sh    = {off, 3'b000};

  // size must be legal and naturally aligned within the word
  always_comb begin
    case (nbytes)
      4'd1:    size_ok = 1'b1;
      4'd2:    size_ok = (off[0] == 1'b0);
      4'd4:    size_ok = (off[1:0] == 2'b00);
      4'd8:    size_ok = (off == 3'b000);
      default: size_ok = 1'b0;
    endcase
  end

  assign lane_mask = smask << sh;
  assign wdata_sh  = (wdata & smask) << sh;
  assign rdata_sh  = (rword >> sh) & smask;
endmodule

// File: rtl/brf_decode.sv
`timescale 1ns/1ps
module brf_decode
  import brf_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int TBL_BYTES = 64,
  parameter int VEC_BASE  = 'h100,
  parameter int RTE_BASE  = 'h200,
  parameter int IDX_W     = 3
)(
  input  logic [ADDR_W-1:0] word_addr,
  output sel_e              sel,
  output logic [IDX_W-1:0]  vec_idx,
  output logic [IDX_W-1:0]  rte_idx
);
  logic [ADDR_W-1:0] vofs, rofs;
  logic              in_vec, in_rte;

  assign vofs   = word_addr - ADDR_W'(VEC_BASE);
  assign rofs   = word_addr - ADDR_W'(RTE_BASE);
  assign in_vec = (word_addr >= ADDR_W'(VEC_BASE)) && (vofs < ADDR_W'(TBL_BYTES));
  assign in_rte = (word_addr >= ADDR_W'(RTE_BASE)) && (rofs < ADDR_W'(TBL_BYTES));
  assign vec_idx = vofs[IDX_W+2:3];
  assign rte_idx = rofs[IDX_W+2:3];

  always_comb begin
    sel = SEL_NONE;
    if      (word_addr == ADDR_W'(OFS_ID))     sel = SEL_ID;
    else if (word_addr == ADDR_W'(OFS_MASK))   sel = SEL_MASK;
    else if (word_addr == ADDR_W'(OFS_EDGE))   sel = SEL_EDGE;
    else if (word_addr == ADDR_W'(OFS_MSIEN))  sel = SEL_MSIEN;
    else if (word_addr == ADDR_W'(OFS_AUTO0))  sel = SEL_AUTO;
    else if (word_addr == ADDR_W'(OFS_AUTO1))  sel = SEL_AUTO;
    else if (word_addr == ADDR_W'(OFS_CLEAR))  sel = SEL_CLEAR;
    else if (word_addr == ADDR_W'(OFS_STATUS)) sel = SEL_STATUS;
    else if (word_addr == ADDR_W'(OFS_POL))    sel = SEL_POL;
    else if (in_vec)                           sel = SEL_VEC;
    else if (in_rte)                           sel = SEL_RTE;
  end
endmodule

// File: rtl/brf_btable.sv
`timescale 1ns/1ps
module brf_btable
  import brf_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int IDX_W = 3,
  parameter int SRC_W = 6
)(
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [LANES-1:0] be,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rword,
  input  logic [SRC_W-1:0] lk_idx,
  output logic [7:0]       lk_byte
);
  logic [REG_W-1:0] mem [WORDS];

  // byte-enabled write, no reset, so it maps onto RAM
  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < LANES; b++) begin
        if (be[b]) mem[idx][b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
  end

  assign rword = mem[idx];

  always_ff @(posedge clk) begin
    lk_byte <= mem[lk_idx[SRC_W-1:3]][{lk_idx[2:0], 3'b000} +: 8];
  end
endmodule

// File: rtl/brf_ctl.sv
`timescale 1ns/1ps
module brf_ctl
  import brf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ok,
  input  sel_e             sel,
  input  logic [REG_W-1:0] lane_mask,
  input  logic [REG_W-1:0] wdata_sh,
  output logic [REG_W-1:0] mask_q,
  output logic [REG_W-1:0] edge_q,
  output logic [REG_W-1:0] msien_q,
  output logic [REG_W-1:0] pol_q,
  output logic             chg_valid,
  output logic [REG_W-1:0] chg_old,
  output logic [REG_W-1:0] chg_new,
  output logic             clr_valid,
  output logic [REG_W-1:0] clr_bits
);
  localparam int NREG = 4;
  localparam sel_e SLOT [NREG] = '{SEL_MASK, SEL_EDGE, SEL_MSIEN, SEL_POL};

  logic [REG_W-1:0] regs   [NREG];
  logic [REG_W-1:0] merged [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign merged[g] = (regs[g] & ~lane_mask) | (wdata_sh & lane_mask);
    always_ff @(posedge clk) begin
      if (rst)                          regs[g] <= '0;
      else if (wr_ok && sel == SLOT[g]) regs[g] <= merged[g];
    end
  end

  assign mask_q  = regs[0];
  assign edge_q  = regs[1];
  assign msien_q = regs[2];
  assign pol_q   = regs[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_valid <= 1'b0;
      chg_old   <= '0;
      chg_new   <= '0;
      clr_valid <= 1'b0;
      clr_bits  <= '0;
    end else begin
      chg_valid <= wr_ok && sel == SEL_MASK;
      clr_valid <= wr_ok && sel == SEL_CLEAR;
      if (wr_ok && sel == SEL_MASK) begin
        chg_old <= regs[0];
        chg_new <= merged[0];
      end
      if (wr_ok && sel == SEL_CLEAR) clr_bits <= wdata_sh & lane_mask;
    end
  end
endmodule

// File: rtl/bytelane_regfile.sv
`timescale 1ns/1ps
module bytelane_regfile
  import brf_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          NUM_SRC  = 64,
  parameter int          VEC_BASE = 'h100,
  parameter int          RTE_BASE = 'h200,
  parameter logic [63:0] ID_VALUE = 64'h0A0B_0C0D_1020_3040,
  localparam int         SRC_W    = $clog2(NUM_SRC)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_bytes,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_err,
  input  logic [63:0]       insvc,
  input  logic [SRC_W-1:0]  lk_idx,
  output logic [7:0]        lk_vec,
  output logic [7:0]        lk_route,
  output logic [63:0]       irq_mask,
  output logic [63:0]       irq_edge,
  output logic [63:0]       irq_pol,
  output logic [63:0]       irq_msi_en,
  output logic              mask_chg_valid,
  output logic [63:0]       mask_chg_old,
  output logic [63:0]       mask_chg_new,
  output logic              clr_valid,
  output logic [63:0]       clr_bits
);
  localparam int TBL_WORDS = NUM_SRC / LANES;
  localparam int IDX_W     = $clog2(TBL_WORDS);

  logic [ADDR_W-1:0] word_addr;
  sel_e              sel;
  logic [IDX_W-1:0]  vec_idx, rte_idx;
  logic              size_ok, acc_ok, wr_ok;
  logic [REG_W-1:0]  lane_mask, wdata_sh, rdata_sh, rword;
  logic [REG_W-1:0]  vec_word, rte_word;
  logic [LANES-1:0]  be;

  assign word_addr = {req_addr[ADDR_W-1:3], 3'b000};

  brf_decode #(
    .ADDR_W(ADDR_W), .TBL_BYTES(NUM_SRC), .VEC_BASE(VEC_BASE),
    .RTE_BASE(RTE_BASE), .IDX_W(IDX_W)
  ) i_dec (
    .word_addr(word_addr), .sel(sel), .vec_idx(vec_idx), .rte_idx(rte_idx)
  );

  brf_lane i_lane (
    .off(req_addr[2:0]), .nbytes(req_bytes), .wdata(req_wdata),
    .rword(rword), .size_ok(size_ok), .lane_mask(lane_mask),
    .wdata_sh(wdata_sh), .rdata_sh(rdata_sh)
  );

  assign acc_ok = size_ok && (sel != SEL_NONE);
  assign wr_ok  = req_valid && req_write && acc_ok;

  for (genvar b = 0; b < LANES; b++) begin : g_be
    assign be[b] = lane_mask[b*8];
  end

  brf_ctl i_ctl (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .sel(sel),
    .lane_mask(lane_mask), .wdata_sh(wdata_sh),
    .mask_q(irq_mask), .edge_q(irq_edge), .msien_q(irq_msi_en), .pol_q(irq_pol),
    .chg_valid(mask_chg_valid), .chg_old(mask_chg_old), .chg_new(mask_chg_new),
    .clr_valid(clr_valid), .clr_bits(clr_bits)
  );

  brf_btable #(.WORDS(TBL_WORDS), .IDX_W(IDX_W), .SRC_W(SRC_W)) i_vec (
    .clk(clk), .we(wr_ok && sel == SEL_VEC), .idx(vec_idx), .be(be),
    .wdata(wdata_sh), .rword(vec_word), .lk_idx(lk_idx), .lk_byte(lk_vec)
  );

  brf_btable #(.WORDS(TBL_WORDS), .IDX_W(IDX_W), .SRC_W(SRC_W)) i_rte (
    .clk(clk), .we(wr_ok && sel == SEL_RTE), .idx(rte_idx), .be(be),
    .wdata(wdata_sh), .rword(rte_word), .lk_idx(lk_idx), .lk_byte(lk_route)
  );

  // word-level read mux; side-effect words return computed or zero values
  always_comb begin
    case (sel)
      SEL_ID:     rword = ID_VALUE;
      SEL_MASK:   rword = irq_mask;
      SEL_EDGE:   rword = irq_edge;
      SEL_MSIEN:  rword = irq_msi_en;
      SEL_POL:    rword = irq_pol;
      SEL_STATUS: rword = insvc & ~irq_mask;
      SEL_VEC:    rword = vec_word;
      SEL_RTE:    rword = rte_word;
      default:    rword = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !acc_ok;
      rsp_rdata <= (req_valid && !req_write && acc_ok) ? rdata_sh : '0;
    end
  end
endmodule

// File: rtl/brf_chk.sv
`timescale 1ns/1ps
module brf_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_write,
  input logic [3:0]  req_bytes,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [63:0] rsp_rdata,
  input logic [63:0] irq_mask,
  input logic        mask_chg_valid,
  input logic [63:0] mask_chg_new,
  input logic        clr_valid
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R5
  AST_RSP_NOT_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R5
  AST_WRITE_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> rsp_rdata == 64'h0); // R5
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_valid && rsp_rdata == 64'h0)); // R3
  AST_BYTE_READ_NARROW: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_bytes == 4'd1) |=> rsp_rdata[63:8] == 56'h0); // R1
  AST_MASK_MOVES_ON_NOTIFY: assert property (@(posedge clk) disable iff (rst)
    !$stable(irq_mask) |-> mask_chg_valid); // R11
  AST_MASK_NEW_MATCHES: assert property (@(posedge clk) disable iff (rst)
    mask_chg_valid |-> mask_chg_new == irq_mask); // R11
  AST_NOTIFY_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    mask_chg_valid |-> $past(req_valid && req_write)); // R11
  AST_CLEAR_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    clr_valid |-> $past(req_valid && req_write)); // R7
endmodule

bind bytelane_regfile brf_chk u_brf_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_bytes(req_bytes), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .rsp_rdata(rsp_rdata), .irq_mask(irq_mask), .mask_chg_valid(mask_chg_valid),
  .mask_chg_new(mask_chg_new), .clr_valid(clr_valid)
);

// File: tb/test_bytelane_regfile.sv
`timescale 1ns/1ps
module test_bytelane_regfile;
  localparam logic [63:0] ID = 64'h0A0B_0C0D_1020_3040;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [3:0]  req_bytes = '0;
  logic [63:0] req_wdata = '0, insvc = '0;
  logic [5:0]  lk_idx = '0;
  logic        rsp_valid, rsp_err, mask_chg_valid, clr_valid;
  logic [63:0] rsp_rdata, irq_mask, irq_edge, irq_pol, irq_msi_en;
  logic [63:0] mask_chg_old, mask_chg_new, clr_bits;
  logic [7:0]  lk_vec, lk_route;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bytelane_regfile #(.ID_VALUE(ID)) i_bytelane_regfile (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .insvc(insvc), .lk_idx(lk_idx), .lk_vec(lk_vec), .lk_route(lk_route),
    .irq_mask(irq_mask), .irq_edge(irq_edge), .irq_pol(irq_pol),
    .irq_msi_en(irq_msi_en), .mask_chg_valid(mask_chg_valid),
    .mask_chg_old(mask_chg_old), .mask_chg_new(mask_chg_new),
    .clr_valid(clr_valid), .clr_bits(clr_bits)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [3:0]  nb;
    logic [63:0] wd;
    logic [63:0] exp;
    logic        err;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h008, 4'd8, 64'h1122_3344_5566_7788, 64'h0, 1'b0, 8'd2},  // R2 full mask write
    '{1'b0, 12'h008, 4'd8, 64'h0, 64'h1122_3344_5566_7788, 1'b0, 8'd1},  // R1
    '{1'b1, 12'h00A, 4'd2, 64'hBEEF, 64'h0, 1'b0, 8'd2},                 // R2 halfword merge
    '{1'b0, 12'h00C, 4'd4, 64'h0, 64'h1122_3344, 1'b0, 8'd1},            // R1 upper word
    '{1'b0, 12'h00A, 4'd2, 64'h0, 64'hBEEF, 1'b0, 8'd1},                 // R1
    '{1'b0, 12'h00F, 4'd1, 64'h0, 64'h11, 1'b0, 8'd1},                   // R1 top byte
    '{1'b1, 12'h00B, 4'd1, 64'h1FF, 64'h0, 1'b0, 8'd2},                  // R2 data trimmed
    '{1'b0, 12'h008, 4'd8, 64'h0, 64'h1122_3344_FFEF_7788, 1'b0, 8'd2},  // R2
    '{1'b1, 12'h009, 4'd2, 64'h0, 64'h0, 1'b1, 8'd3},                    // R3 misaligned
    '{1'b0, 12'h008, 4'd8, 64'h0, 64'h1122_3344_FFEF_7788, 1'b0, 8'd3},  // R3 unchanged
    '{1'b0, 12'h008, 4'd3, 64'h0, 64'h0, 1'b1, 8'd3},                    // R3 bad size
    '{1'b0, 12'h00C, 4'd8, 64'h0, 64'h0, 1'b1, 8'd3},                    // R3 crosses word
    '{1'b1, 12'h020, 4'd8, ONES, 64'h0, 1'b0, 8'd8},                     // R8
    '{1'b0, 12'h020, 4'd8, 64'h0, 64'h0, 1'b0, 8'd8},                    // R8
    '{1'b1, 12'h02C, 4'd4, 64'hFFFF_FFFF, 64'h0, 1'b0, 8'd8},            // R8
    '{1'b0, 12'h028, 4'd8, 64'h0, 64'h0, 1'b0, 8'd8},                    // R8
    '{1'b0, 12'h050, 4'd8, 64'h0, 64'h0, 1'b1, 8'd4},                    // R4
    '{1'b1, 12'h050, 4'd8, 64'h1, 64'h0, 1'b1, 8'd4},                    // R4
    '{1'b1, 12'h108, 4'd4, 64'hA1B2_C3D4, 64'h0, 1'b0, 8'd10},           // R10
    '{1'b0, 12'h10A, 4'd1, 64'h0, 64'hB2, 1'b0, 8'd10},                  // R10
    '{1'b0, 12'h108, 4'd4, 64'h0, 64'hA1B2_C3D4, 1'b0, 8'd10},           // R10
    '{1'b1, 12'h23C, 4'd4, 64'h0102_0304, 64'h0, 1'b0, 8'd10},           // R10 last word
    '{1'b0, 12'h23C, 4'd4, 64'h0, 64'h0102_0304, 1'b0, 8'd10},           // R10
    '{1'b0, 12'h23F, 4'd1, 64'h0, 64'h01, 1'b0, 8'd10},                  // R10
    '{1'b0, 12'h240, 4'd1, 64'h0, 64'h0, 1'b1, 8'd10},                   // R10 past end
    '{1'b0, 12'h000, 4'd8, 64'h0, ID, 1'b0, 8'd9},                       // R9
    '{1'b1, 12'h000, 4'd8, ONES, 64'h0, 1'b0, 8'd9},                     // R9
    '{1'b0, 12'h004, 4'd4, 64'h0, 64'h0A0B_0C0D, 1'b0, 8'd9},            // R9
    '{1'b1, 12'h010, 4'd1, 64'h5A, 64'h0, 1'b0, 8'd2},                   // R2 edge
    '{1'b0, 12'h010, 4'd8, 64'h0, 64'h5A, 1'b0, 8'd2},                   // R2
    '{1'b1, 12'h044, 4'd4, 64'hCAFE_F00D, 64'h0, 1'b0, 8'd2},            // R2 polarity
    '{1'b0, 12'h040, 4'd8, 64'h0, 64'hCAFE_F00D_0000_0000, 1'b0, 8'd1},  // R1
    '{1'b1, 12'h018, 4'd2, 64'h1234, 64'h0, 1'b0, 8'd2},                 // R2 msg enable
    '{1'b0, 12'h018, 4'd2, 64'h0, 64'h1234, 1'b0, 8'd1},                 // R1
    '{1'b1, 12'h030, 4'd8, 64'h5, 64'h0, 1'b0, 8'd7},                    // R7
    '{1'b0, 12'h030, 4'd8, 64'h0, 64'h0, 1'b0, 8'd7},                    // R7
    '{1'b1, 12'h038, 4'd8, ONES, 64'h0, 1'b0, 8'd6},                     // R6 write ignored
    '{1'b0, 12'h038, 4'd8, 64'h0, 64'h0, 1'b0, 8'd6}                     // R6
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [11:0] a, input logic [3:0] nb,
                        input logic [63:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_bytes = nb; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    chk("R13 rsp_valid", 64'(rsp_valid), 64'h0);
    chk("R13 rsp_err", 64'(rsp_err), 64'h0);
    chk("R13 mask", irq_mask, 64'h0);
    chk("R13 edge", irq_edge, 64'h0);
    chk("R13 pol", irq_pol, 64'h0);
    chk("R13 msi_en", irq_msi_en, 64'h0);
    chk("R13 strobes", {62'h0, clr_valid, mask_chg_valid}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].addr, VECS[i].nb, VECS[i].wd);
      chk($sformatf("R%0d vec%0d rdata", VECS[i].req, i), rsp_rdata, VECS[i].exp);
      chk($sformatf("R%0d vec%0d err", VECS[i].req, i), 64'(rsp_err), 64'(VECS[i].err));
      chk($sformatf("R5 vec%0d rsp_valid", i), 64'(rsp_valid), 64'h1);
    end
    @(negedge clk);
    chk("R5 rsp_valid drops", 64'(rsp_valid), 64'h0);

    // R11 mask notification, full word
    access(1'b1, 12'h008, 4'd8, 64'h00FF_00FF_00FF_00FF);
    chk("R11 chg_valid", 64'(mask_chg_valid), 64'h1);
    chk("R11 chg_old", mask_chg_old, 64'h1122_3344_FFEF_7788);
    chk("R11 chg_new", mask_chg_new, 64'h00FF_00FF_00FF_00FF);
    @(negedge clk);
    chk("R11 chg_valid one cycle", 64'(mask_chg_valid), 64'h0);

    // R6 status = insvc & ~mask
    insvc = 64'h0F0F_0F0F_0F0F_0F0F;
    access(1'b0, 12'h038, 4'd8, 64'h0);
    chk("R6 status word", rsp_rdata, 64'h0F00_0F00_0F00_0F00);
    access(1'b0, 12'h03C, 4'd4, 64'h0);
    chk("R6 status upper", rsp_rdata, 64'h0F00_0F00);

    // R11 byte write to mask
    access(1'b1, 12'h008, 4'd1, 64'h33);
    chk("R11 byte chg_old", mask_chg_old, 64'h00FF_00FF_00FF_00FF);
    chk("R11 byte chg_new", mask_chg_new, 64'h00FF_00FF_00FF_0033);
    chk("R11 irq_mask", irq_mask, 64'h00FF_00FF_00FF_0033);

    // R7 clear strobe
    access(1'b1, 12'h034, 4'd2, 64'hABCD);
    chk("R7 clr_valid", 64'(clr_valid), 64'h1);
    chk("R7 clr_bits", clr_bits, 64'h0000_ABCD_0000_0000);
    chk("R7 mask untouched", irq_mask, 64'h00FF_00FF_00FF_0033);
    @(negedge clk);
    chk("R7 clr one cycle", 64'(clr_valid), 64'h0);
    access(1'b1, 12'h030, 4'd3, 64'hFF);
    chk("R3 bad clear no strobe", 64'(clr_valid), 64'h0);

    // R12 lookup port
    @(negedge clk); lk_idx = 6'd10;
    @(negedge clk);
    chk("R12 lk_vec", 64'(lk_vec), 64'hB2);
    lk_idx = 6'd63;
    @(negedge clk);
    chk("R12 lk_route", 64'(lk_route), 64'h01);

    // R13 reset clears control words again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R13 mask after reset", irq_mask, 64'h0);
    chk("R13 pol after reset", irq_pol, 64'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule